// File: doc/BRIEF.md
# APB Requester Transfer Sequencer

This block sits between a local command source and one APB completer. A command source offers a transfer with a valid flag, a direction bit, an address and write data. The block takes the command, runs the bus through its setup and access phases, and stretches the access phase for as long as the completer holds PREADY low. On the completing cycle it hands back the read data and the error status, together with a one-cycle done pulse.

If the next command is already waiting when a transfer completes, the block takes it on that same cycle. It then goes straight into the setup phase of the new transfer instead of first dropping to idle. A build parameter can turn this chaining off, so that every transfer passes through idle.

Top module: `apb_xfer_seq`

## Requirements
- R1: While rst_n is low and on the first cycle after it rises, psel and penable are 0, cmd_ready is 1 and rsp_done is 0.
- R2: The cycle after a command is taken (cmd_valid and cmd_ready both 1 at a rising edge) is a setup cycle: psel is 1 and penable is 0. It lasts exactly one cycle and is followed by an access cycle with psel and penable both 1.
- R3: From the setup cycle through the completing access cycle, paddr, pwrite and pwdata equal the fields of the command that was taken, and they do not change.
- R4: While penable is 1 and pready is 0, the block stays in the access phase (psel and penable stay 1) and rsp_done stays 0.
- R5: rsp_done is 1 exactly on cycles with psel, penable and pready all 1. On that cycle rsp_rdata equals prdata. Outside such cycles rsp_rdata and rsp_err keep the last captured values.
- R6: pwrite is 1 for a write command (cmd_write=1) and 0 for a read. On the completing cycle rsp_err equals pslverr, where 1 means error and 0 means okay.
- R7: If a command is taken on a completing cycle, the next cycle is a setup cycle of the new transfer (psel 1, penable 0). If no command is taken, psel is 0 on the next cycle.
- R8: cmd_ready is 0 during the setup cycle and during access cycles with pready 0. A cmd_valid offered then starts no transfer and does not alter paddr, pwrite or pwdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | A command can be taken this cycle |
| cmd_write | input | 1 | 1 for write, 0 for read |
| cmd_addr | input | ADDR_W | Command address |
| cmd_wdata | input | DATA_W | Command write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data of the completed transfer |
| rsp_err | output | 1 | Error status of the completed transfer |
| psel | output | 1 | Completer select |
| penable | output | 1 | Access phase indicator |
| paddr | output | ADDR_W | Bus address |
| pwrite | output | 1 | Bus direction |
| pwdata | output | DATA_W | Bus write data |
| pready | input | 1 | Completer ready |
| prdata | input | DATA_W | Completer read data |
| pslverr | input | 1 | Completer error |

## Verification
Two things can happen on one cycle: the completion of the current transfer, with its done pulse and response capture, and the acceptance of the next command. The bench provokes this by issuing commands back to back, so that the next command is already waiting while the completer answers after zero to three wait states. A scoreboard checks that the response returned on that cycle belongs to the old transfer. It also checks that the following cycle is a setup cycle carrying the new address, direction and data, and that a command offered while the bus is busy leaves the bus fields alone.

// File: rtl/apb_seq_pkg.sv
package apb_seq_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SETUP  = 2'd1,
      ST_ACCESS = 2'd2
   } seq_state_e;
endpackage

// File: rtl/apb_seq_hold.sv
module apb_seq_hold #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= d;
   end
endmodule

// File: rtl/apb_seq_ctrl.sv
module apb_seq_ctrl
   import apb_seq_pkg::*;
#(
   parameter bit CHAIN_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid,
   input  logic       pready,
   output seq_state_e state,
   output logic       cmd_ready,
   output logic       take,
   output logic       done
);
   seq_state_e nxt;
   logic       chain_ok;

   generate
      if (CHAIN_EN) begin : g_chain
         assign chain_ok = 1'b1;
      end else begin : g_via_idle
         assign chain_ok = 1'b0;
      end
   endgenerate

   assign done = (state == ST_ACCESS) && pready;
   assign take = cmd_valid && cmd_ready;

   always_comb begin
      case (state)
         ST_IDLE:   cmd_ready = 1'b1;
         ST_ACCESS: cmd_ready = pready && chain_ok;
         default:   cmd_ready = 1'b0;
      endcase
   end

   always_comb begin
      nxt = state;
      case (state)
         ST_IDLE:   if (take) nxt = ST_SETUP;
         ST_SETUP:  nxt = ST_ACCESS;
         ST_ACCESS: if (pready) nxt = take ? ST_SETUP : ST_IDLE;
         default:   nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end
endmodule

// File: rtl/apb_xfer_seq.sv
module apb_xfer_seq
   import apb_seq_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 32,
   parameter bit CHAIN_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic              cmd_write,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_wdata,
   output logic              rsp_done,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_err,
   output logic              psel,
   output logic              penable,
   output logic [ADDR_W-1:0] paddr,
   output logic              pwrite,
   output logic [DATA_W-1:0] pwdata,
   input  logic              pready,
   input  logic [DATA_W-1:0] prdata,
   input  logic              pslverr
);
   localparam int CMD_W = ADDR_W + DATA_W + 1;
   localparam int RSP_W = DATA_W + 1;

   generate
      if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr
         $error("apb_xfer_seq: ADDR_W must be 1..32");
      end
      if (DATA_W != 8 && DATA_W != 16 && DATA_W != 32) begin : g_bad_data
         $error("apb_xfer_seq: DATA_W must be 8, 16 or 32");
      end
   endgenerate

   seq_state_e       state;
   logic             take;
   logic             done;
   logic [CMD_W-1:0] cmd_q;
   logic [RSP_W-1:0] rsp_q;

   apb_seq_ctrl #(.CHAIN_EN(CHAIN_EN)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .pready    (pready),
      .state     (state),
      .cmd_ready (cmd_ready),
      .take      (take),
      .done      (done)
   );

   apb_seq_hold #(.W(CMD_W)) u_cmd (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (take),
      .d     ({cmd_write, cmd_addr, cmd_wdata}),
      .q     (cmd_q)
   );

   apb_seq_hold #(.W(RSP_W)) u_rsp (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (done),
      .d     ({pslverr, prdata}),
      .q     (rsp_q)
   );

   assign psel    = (state != ST_IDLE);
   assign penable = (state == ST_ACCESS);
   assign {pwrite, paddr, pwdata} = cmd_q;

   assign rsp_done  = done;
   assign rsp_rdata = done ? prdata  : rsp_q[DATA_W-1:0];
   assign rsp_err   = done ? pslverr : rsp_q[DATA_W];
endmodule

// File: rtl/apb_xfer_seq_chk.sv
module apb_xfer_seq_chk #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic              cmd_ready,
   input logic              rsp_done,
   input logic [DATA_W-1:0] rsp_rdata,
   input logic              rsp_err,
   input logic              psel,
   input logic              penable,
   input logic [ADDR_W-1:0] paddr,
   input logic              pwrite,
   input logic [DATA_W-1:0] pwdata,
   input logic              pready,
   input logic [DATA_W-1:0] prdata,
   input logic              pslverr
);
   AST_SETUP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && !penable) |=> (psel && penable)); // R2

   AST_SETUP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && !penable) |=> ($stable(paddr) && $stable(pwrite) && $stable(pwdata))); // R3

   AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && penable && !pready) |=> (psel && penable && $stable(paddr)
                                        && $stable(pwrite) && $stable(pwdata))); // R4

   AST_ENABLE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      penable |-> psel); // R2

   AST_DONE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> (psel && penable && pready && rsp_rdata == prdata && rsp_err == pslverr)); // R5

   AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!rsp_done && $past(rst_n)) |-> ($stable(rsp_rdata) && $stable(rsp_err))); // R5

   AST_CHAIN_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && penable && pready && cmd_valid && cmd_ready) |=> (psel && !penable)); // R7

   AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && penable && pready && !cmd_valid) |=> !psel); // R7

   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && !(penable && pready)) |-> !cmd_ready); // R8
endmodule

bind apb_xfer_seq apb_xfer_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_ready (cmd_ready),
   .rsp_done  (rsp_done),
   .rsp_rdata (rsp_rdata),
   .rsp_err   (rsp_err),
   .psel      (psel),
   .penable   (penable),
   .paddr     (paddr),
   .pwrite    (pwrite),
   .pwdata    (pwdata),
   .pready    (pready),
   .prdata    (prdata),
   .pslverr   (pslverr)
);

// File: tb/apb_xfer_seq_test.sv
module apb_xfer_seq_test;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        cmd_valid, cmd_ready, cmd_write;
   logic [31:0] cmd_addr, cmd_wdata;
   logic        rsp_done, rsp_err;
   logic [31:0] rsp_rdata;
   logic        psel, penable, pwrite;
   logic [31:0] paddr, pwdata;
   logic        pready = 1'b0;
   logic [31:0] prdata = '0;
   logic        pslverr = 1'b0;

   always #5 clk = ~clk;

   apb_xfer_seq uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
      .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
      .psel(psel), .penable(penable), .paddr(paddr), .pwrite(pwrite),
      .pwdata(pwdata), .pready(pready), .prdata(prdata), .pslverr(pslverr)
   );

   typedef struct {
      logic        wr;
      logic [31:0] addr;
      logic [31:0] wdata;
      logic [31:0] rdata;
      logic        err;
   } exp_t;

   exp_t q[$];
   int   total = 0;
   int   bad   = 0;
   bit   mon_on = 1'b0;

   // completer model: wait states = addr[3:2], error when addr[4]
   function automatic logic [31:0] rd_of(logic [31:0] a);
      return a ^ 32'h5A5A_0000;
   endfunction

   task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   int wcnt = 0;
   always @(negedge clk) begin
      if (psel && penable) begin
         if (wcnt == int'(paddr[3:2])) begin
            pready  <= 1'b1;
            prdata  <= rd_of(paddr);
            pslverr <= paddr[4];
         end else begin
            pready <= 1'b0;
            wcnt   <= wcnt + 1;
         end
      end else begin
         pready  <= 1'b0;
         prdata  <= '0;
         pslverr <= 1'b0;
         wcnt    <= 0;
      end
   end

   // scoreboard monitor
   bit          prev_setup = 0, prev_chain = 0, prev_end = 0, have_last = 0;
   logic [31:0] last_rd;
   logic        last_err;
   always @(negedge clk) begin
      #2;
      if (mon_on) begin
         if (psel && !penable) chk(!cmd_ready, "R8", "cmd_ready in setup", 32'(cmd_ready), 0);
         if (prev_setup) chk(psel && penable, "R2", "access after setup", {psel, penable}, 2'b11);
         if (prev_chain) chk(psel && !penable, "R7", "setup after chained take", {psel, penable}, 2'b10);
         if (prev_end)   chk(!psel, "R7", "idle after last transfer", 32'(psel), 0);
         if (psel) begin
            if (q.size() == 0) chk(0, "R3", "bus active with empty scoreboard", paddr, 0);
            else begin
               chk(paddr == q[0].addr, "R3", "paddr", paddr, q[0].addr);
               chk(pwrite == q[0].wr, "R6", "pwrite", 32'(pwrite), 32'(q[0].wr));
               chk(pwdata == q[0].wdata, "R3", "pwdata", pwdata, q[0].wdata);
               if (penable && pready) begin
                  chk(rsp_done, "R5", "done on completion", 32'(rsp_done), 1);
                  chk(rsp_rdata == q[0].rdata, "R5", "rsp_rdata", rsp_rdata, q[0].rdata);
                  chk(rsp_err == q[0].err, "R6", "rsp_err", 32'(rsp_err), 32'(q[0].err));
                  last_rd = q[0].rdata; last_err = q[0].err; have_last = 1;
                  void'(q.pop_front());
               end else begin
                  chk(!rsp_done, "R4", "no done while waiting", 32'(rsp_done), 0);
               end
            end
         end else begin
            chk(!rsp_done, "R5", "no done when idle", 32'(rsp_done), 0);
         end
         if (!(psel && penable && pready) && have_last) begin
            chk(rsp_rdata == last_rd, "R5", "rsp_rdata held", rsp_rdata, last_rd);
            chk(rsp_err == last_err, "R5", "rsp_err held", 32'(rsp_err), 32'(last_err));
         end
         prev_setup = psel && !penable;
         prev_chain = psel && penable && pready && cmd_valid && cmd_ready;
         prev_end   = psel && penable && pready && !(cmd_valid && cmd_ready);
      end
   end

   task automatic issue(bit wr, logic [31:0] a, logic [31:0] d);
      exp_t e;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = d;
      #2;
      while (!cmd_ready) begin
         @(negedge clk);
         #2;
      end
      e.wr = wr; e.addr = a; e.wdata = d; e.rdata = rd_of(a); e.err = a[4];
      q.push_back(e);
      @(posedge clk);
      #1;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         cmd_valid = 1'b0;
      end
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; cmd_valid = 1'b1; cmd_write = 1'b1;
      cmd_addr = 32'h0000_0200; cmd_wdata = 32'h1111_2222;
      repeat (3) @(negedge clk);
      #2;
      // R1: reset state, valid ignored during reset
      chk(!psel && !penable, "R1", "bus idle in reset", {psel, penable}, 0);
      chk(cmd_ready, "R1", "cmd_ready in reset", 32'(cmd_ready), 1);
      chk(!rsp_done, "R1", "rsp_done in reset", 32'(rsp_done), 0);
      cmd_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #2;
      chk(!psel && !penable && cmd_ready, "R1", "idle after reset", {psel, penable, cmd_ready}, 3'b001);
      mon_on = 1'b1;

      // single write, no wait
      issue(1'b1, 32'h0000_0100, 32'hCAFE_0001);
      idle(4);
      // R8: read with three wait states, busy offers ignored
      issue(1'b0, 32'h0000_010C, 32'h0);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = 32'hDEAD_0000 + i; cmd_wdata = 32'hBAD0_0000;
      end
      idle(6);
      // R6: error response with one wait
      issue(1'b0, 32'h0000_0114, 32'h0);
      idle(4);
      // R7: back-to-back chained commands
      issue(1'b1, 32'h0000_0200, 32'h0A0A_0001);
      issue(1'b0, 32'h0000_0218, 32'h0);
      issue(1'b1, 32'h0000_0204, 32'h0A0A_0003);
      issue(1'b0, 32'h0000_0210, 32'h0);
      idle(8);
      // mixed pattern
      for (int i = 0; i < 24; i++) begin
         issue(i[0], 32'h0000_0400 + 32'(i * 4), 32'h7000_0000 + 32'(i));
         if (i % 5 == 4) idle(2);
      end
      idle(20);
      chk(q.size() == 0, "R5", "all transfers completed", q.size(), 0);
      finish_run();
   end
endmodule